// File: doc/BRIEF.md
# Dual Privilege-Gated Event Counter

This block holds two 40-bit event counters and one 64-bit control word. Each counter picks one line out of a 128-line vector of one-cycle event strobes using a 7-bit select code. The counter can instead count every clock cycle. Counting is allowed separately for the most privileged levels (0, 1, 2) and for the least privileged level (3), based on a 2-bit privilege input. Each counter drives one monitor pin. The pin gives a one-cycle registered pulse either on every increment or only when the counter wraps.

Software reaches the control word and both counters through a simple port with an address, a write strobe, write data and combinational read data. Address 0 selects the control word, address 1 counter 0, address 2 counter 1, and address 3 reads zero. A parameter lists which select codes have an event assigned. Any unassigned code never counts.

Top module: `dual_evt_counter`

## Requirements
- R1: After reset the control word, both counters and both monitor pins read zero, and nothing counts until software sets an enable.
- R2: Control bits 5:0 hold the low six select bits for counter 0, and bits 21:16 hold them for counter 1. A strobe on the selected line adds one to that counter in the clock edge where it is high.
- R3: Bit 6 (counter 0) and bit 22 (counter 1) allow counting while the privilege input is 0, 1 or 2. Bit 7 and bit 23 allow counting while it is 3.
- R4: Bit 8 (counter 0) and bit 24 (counter 1) make the counter add one on every enabled clock edge, whatever the event lines do.
- R5: Bit 9 (counter 0) and bit 25 (counter 1) switch that counter's monitor pin from pulsing on each increment to pulsing only on wrap. The pin is high for exactly the one cycle after the edge that caused the pulse.
- R6: Control bits 15:11 and 63:27 always read zero, and writes to them are dropped.
- R7: With the extension enabled (default), bit 10 and bit 26 are select bit 6 for counter 0 and counter 1, which reaches codes up to 7Fh.
- R8: A select code that has no event assigned never increments the counter, even when its strobe line is high. By default codes 00h–29h, 40h–46h and 48h are assigned.
- R9: Each counter is 40 bits wide, readable and writable at its address, and reads back zero-extended. A write truncates the data to 40 bits and wins over an increment in the same edge.
- R10: A counter that increments from all ones wraps to zero, and that edge counts as an overflow.
- R11: When both privilege enables of a counter are clear, the counter holds its value even with cycle mode set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 counter 0, 2 counter 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| priv_lvl | input | 2 | Current privilege level |
| evt_in | input | 128 | One-cycle event strobes, indexed by select code |
| mon_pin | output | 2 | Monitor pulse per counter |

## Verification
If the enable or select decode is wrong, the counter value read back after the next few edges is off by one or more counts. Such an error shows within one access after a single stimulus window. If the increment and overflow qualifiers are wrong, the monitor pin shows it one cycle after the edge in question, as a pulse that is missing, extra or too long. A wrong write-versus-increment priority shows up as a count that is one too high right after the write. Masking errors in the control word show at once on read-back.

// File: rtl/dec_pkg.sv
package dec_pkg;

  localparam int CTRL_W = 64;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic       ovf_pin;
    logic       cyc;
    logic       en_usr;
    logic       en_sup;
    logic [6:0] code;
  } slice_cfg_t;

  // Bits that software may change in the control word.
  function automatic logic [CTRL_W-1:0] ctrl_wmask(input bit ext);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 10; b++) m[s*HALF_W + b] = 1'b1;
      if (ext) m[s*HALF_W + 10] = 1'b1;
    end
    return m;
  endfunction

  // Extract per-counter settings from the control word.
  function automatic slice_cfg_t get_cfg(input logic [CTRL_W-1:0] c, input int idx);
    logic [HALF_W-1:0] h;
    slice_cfg_t r;
    h = HALF_W'(c >> (idx * HALF_W));
    r.code    = {h[10], h[5:0]};
    r.en_sup  = h[6];
    r.en_usr  = h[7];
    r.cyc     = h[8];
    r.ovf_pin = h[9];
    return r;
  endfunction

  // Privilege qualifier: level 3 uses the user enable, others the supervisor one.
  function automatic logic priv_allows(input slice_cfg_t c, input logic [1:0] lvl);
    return (lvl == 2'd3) ? c.en_usr : c.en_sup;
  endfunction

endpackage

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import dec_pkg::*;
#(
  parameter bit EXT_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl
);
  localparam logic [CTRL_W-1:0] WMASK = ctrl_wmask(EXT_SEL);

  always_ff @(posedge clk) begin
    if (rst)     ctrl <= '0;
    else if (wr) ctrl <= wdata & WMASK;
  end

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl & ~WMASK) == '0);

endmodule

// File: rtl/evt_select.sv
module evt_select #(
  parameter int SEL_W = 7,
  parameter int EVT_N = 128,
  parameter logic [EVT_N-1:0] VALID = '1
) (
  input  logic [EVT_N-1:0] evt,
  input  logic [SEL_W-1:0] code,
  output logic             hit
);
  logic assigned;

  always_comb begin
    assigned = VALID[code];
    hit      = assigned & evt[code];
  end

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import dec_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  slice_cfg_t       cfg,
  input  logic [1:0]       priv,
  input  logic             evt_hit,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             pin
);
  logic priv_ok;
  logic inc_take;
  logic ovf;

  always_comb begin
    priv_ok  = priv_allows(cfg, priv);
    inc_take = priv_ok & (cfg.cyc | evt_hit) & ~wr;
    ovf      = inc_take & (&cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pin <= 1'b0;
    end else begin
      if (wr)            cnt <= wdata;
      else if (inc_take) cnt <= cnt + 1'b1;
      pin <= cfg.ovf_pin ? ovf : inc_take;
    end
  end

  // R5
  pin_source_chk: assert property (@(posedge clk) disable iff (rst)
    pin |-> $past(inc_take));
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> cnt == $past(wdata));
  // R10
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> cnt == '0);
  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.en_sup && !cfg.en_usr && !wr) |=> $stable(cnt));

endmodule

// File: rtl/dual_evt_counter.sv
module dual_evt_counter
  import dec_pkg::*;
#(
  parameter int  CNT_W   = 40,
  parameter int  SEL_W   = 7,
  parameter bit  EXT_SEL = 1'b1,
  parameter logic [(1<<SEL_W)-1:0] VALID =
    128'h0000_0000_0000_017F_0000_03FF_FFFF_FFFF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              reg_addr,
  input  logic                    reg_wr,
  input  logic [CTRL_W-1:0]       reg_wdata,
  output logic [CTRL_W-1:0]       reg_rdata,
  input  logic [1:0]              priv_lvl,
  input  logic [(1<<SEL_W)-1:0]   evt_in,
  output logic [1:0]              mon_pin
);
  localparam int EVT_N = 1 << SEL_W;
  localparam int NCNT  = 2;

  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  cnt_q [NCNT];

  ctrl_reg #(.EXT_SEL(EXT_SEL)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr(reg_wr && reg_addr == 2'd0),
    .wdata(reg_wdata), .ctrl(ctrl)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    slice_cfg_t cfg;
    logic       hit;
    logic       wr_me;

    always_comb begin
      cfg   = get_cfg(ctrl, g);
      wr_me = reg_wr && (reg_addr == 2'(g + 1));
    end

    evt_select #(.SEL_W(SEL_W), .EVT_N(EVT_N), .VALID(VALID)) u_sel (
      .evt(evt_in), .code(cfg.code[SEL_W-1:0]), .hit(hit)
    );

    cnt_slice #(.CNT_W(CNT_W)) u_slice (
      .clk(clk), .rst(rst), .cfg(cfg), .priv(priv_lvl), .evt_hit(hit),
      .wr(wr_me), .wdata(reg_wdata[CNT_W-1:0]),
      .cnt(cnt_q[g]), .pin(mon_pin[g])
    );
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl;
      2'd1:    reg_rdata = CTRL_W'(cnt_q[0]);
      2'd2:    reg_rdata = CTRL_W'(cnt_q[1]);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: tb/test_dual_evt_counter.sv
module test_dual_evt_counter;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic [1:0]   priv_lvl = '0;
  logic [127:0] evt_in = '0;
  logic [1:0]   mon_pin;

  int n_run = 0;
  int n_fail = 0;

  dual_evt_counter i_dual_evt_counter (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .priv_lvl(priv_lvl),
    .evt_in(evt_in), .mon_pin(mon_pin)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [63:0] ctrl;
    logic [1:0]  priv;
    logic [6:0]  line;
    logic [1:0]  d0;
    logic [1:0]  d1;
  } vec_t;

  // Window: ctrl write edge, one strobe edge, ctrl clear edge (counts in last two).
  localparam vec_t VEC [10] = '{
    '{64'h0000_0045, 2'd0, 7'h05, 2'd1, 2'd0},  // R2 R3 sup enable
    '{64'h0000_0045, 2'd3, 7'h05, 2'd0, 2'd0},  // R3 level 3 blocked
    '{64'h0000_0085, 2'd3, 7'h05, 2'd1, 2'd0},  // R3 user enable
    '{64'h0052_0000, 2'd1, 7'h12, 2'd0, 2'd1},  // R2 counter 1 field
    '{64'h0000_0140, 2'd2, 7'h00, 2'd2, 2'd0},  // R4 cycle mode c0
    '{64'h01C0_0000, 2'd3, 7'h00, 2'd0, 2'd2},  // R4 cycle mode c1
    '{64'h00EA_00EA, 2'd0, 7'h2A, 2'd0, 2'd0},  // R8 unassigned code
    '{64'h0000_0441, 2'd0, 7'h41, 2'd1, 2'd0},  // R7 extended select
    '{64'h0100_0100, 2'd0, 7'h00, 2'd0, 2'd0},  // R11 no enables
    '{64'h0000_0043, 2'd0, 7'h04, 2'd0, 2'd0}   // R2 other line ignored
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr_reg(input logic [1:0] a, input logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd_reg(2'd0, r); chk("R1 ctrl", r, 64'h0);
    rd_reg(2'd1, r); chk("R1 cnt0", r, 64'h0);
    rd_reg(2'd2, r); chk("R1 cnt1", r, 64'h0);
    chk("R1 pins", {62'h0, mon_pin}, 64'h0);
    rd_reg(2'd3, r); chk("R9 addr3", r, 64'h0);

    for (int i = 0; i < 10; i++) begin
      wr_reg(2'd1, 64'h0);
      wr_reg(2'd2, 64'h0);
      priv_lvl = VEC[i].priv;
      wr_reg(2'd0, VEC[i].ctrl);
      evt_in = '0; evt_in[VEC[i].line] = 1'b1;
      @(negedge clk);
      evt_in = '0;
      wr_reg(2'd0, 64'h0);
      rd_reg(2'd1, r); chk($sformatf("vec%0d cnt0", i), r, 64'(VEC[i].d0));
      rd_reg(2'd2, r); chk($sformatf("vec%0d cnt1", i), r, 64'(VEC[i].d1));
    end

    // R6 reserved bits
    wr_reg(2'd0, '1);
    rd_reg(2'd0, r); chk("R6 ctrl mask", r, 64'h0000_0000_07FF_07FF);
    wr_reg(2'd0, 64'h0);

    // R10 / R5 overflow pin mode
    priv_lvl = 2'd0;
    wr_reg(2'd1, 64'h0000_00FF_FFFF_FFFF);
    wr_reg(2'd0, 64'h0000_0340);
    chk("R5 pin before wrap", {62'h0, mon_pin}, 64'h0);
    @(negedge clk);
    rd_reg(2'd1, r); chk("R10 wrap", r, 64'h0);
    chk("R5 ovf pulse", {62'h0, mon_pin}, 64'h1);
    @(negedge clk);
    chk("R5 pulse one cycle", {62'h0, mon_pin}, 64'h0);
    wr_reg(2'd0, 64'h0000_0140);
    chk("R5 no pulse w/o wrap", {62'h0, mon_pin}, 64'h0);
    @(negedge clk);
    chk("R5 inc pulse", {62'h0, mon_pin}, 64'h1);
    wr_reg(2'd0, 64'h0);
    @(negedge clk);
    chk("R5 pin idle", {62'h0, mon_pin}, 64'h0);
    rd_reg(2'd1, r); chk("R4 count after wrap", r, 64'h4);

    // R9 write beats increment, truncation
    wr_reg(2'd1, 64'h0);
    wr_reg(2'd0, 64'h0000_0140);
    @(negedge clk);
    wr_reg(2'd1, 64'hFFFF_FF12_3456_789A);
    rd_reg(2'd1, r); chk("R9 write priority", r, 64'h0000_0012_3456_789A);
    wr_reg(2'd0, 64'h0);
    rd_reg(2'd1, r); chk("R9 resume count", r, 64'h0000_0012_3456_789B);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule